// File: doc/BRIEF.md
# Write-Readback Traffic Checker

This block drives one port of a memory controller with a self-contained test. A start pulse launches a fixed burst of writes to consecutive addresses, each carrying a data word derived from the port number and the address. Once every write has been accepted, the block reads the same locations back. It tracks each outstanding read by its tag and compares the returned payload with the word it wrote.

Two sticky flags summarise the run. The first says that every request has been issued. The second says that every response matched. A third flag reports a failed run: a mismatch, a stray or duplicate response, or read data that does not return within a programmable window.

Several copies can sit side by side, one per controller port. Each copy is given its own port number, which makes its data pattern distinct from the others. Requests leave on a valid/ready channel. Read data comes back on a response channel that has a valid strobe and no backpressure.

Top module: `rdbk_traffic_gen`

## Requirements
- R1: A synchronous reset or the idle state after reset leaves `req_valid`, `gen_done`, `chk_pass` and `chk_fail` low, and no request is issued until `start` is pulsed.
- R2: After `start`, the block issues NUM_REQ write requests to addresses BASE+i in increasing order, with `req_tag` = i and `req_wdata` = {PORT_ID in bits 31:24, inverted addr[7:0] in bits 23:16, addr[15:0] in bits 15:0}.
- R3: No read is issued before the last write has been accepted. NUM_REQ reads then follow to the same addresses in the same order, again with `req_tag` = i, and no write follows until the next `start`.
- R4: While `req_valid` is high and `req_ready` is low, the command and address hold their values.
- R5: `gen_done` goes high on the cycle after the last read is accepted, while responses may still be outstanding, and stays high until `start` or reset.
- R6: If every outstanding tag returns exactly once, in any order, with the expected data, `chk_pass` goes high and `chk_fail` stays low.
- R7: If any returned payload differs from the word written to that tag's address, the run ends with `chk_fail` high and `chk_pass` low.
- R8: Each of the following is an error that ends the run with `chk_fail` high: a response whose tag is NUM_REQ or above, a response whose tag is not outstanding, and a response during the write phase. A response after the run has finished raises `chk_fail` and clears `chk_pass`.
- R9: A counter starts at zero on the first cycle of the read phase. If the cycle in which it equals `timeout_lim` arrives with reads still outstanding, `chk_fail` is high from the next cycle.
- R10: A `start` pulse in any state clears all three flags and restarts the sequence from the first write.
- R11: `chk_pass` and `chk_fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that starts or restarts a run |
| timeout_lim | input | TW | Read-phase cycle limit |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted when high together with valid |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | AW | Request address |
| req_tag | output | IW+1 | Request tag (burst index) |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read response strobe |
| rsp_tag | input | IW+1 | Tag of the returned read |
| rsp_data | input | 32 | Returned read data |
| gen_done | output | 1 | All requests issued (sticky) |
| chk_pass | output | 1 | All responses matched (sticky) |
| chk_fail | output | 1 | Run failed (sticky) |

## Verification
The hardest case to reach from the ports is the timeout boundary. It needs one missing read, with every other response arriving cleanly, so that only the counter can end the run. The stimulus has the behavioural memory silently drop the response to a single tag. The bench then counts cycles from the first read request it observes, and checks that `chk_fail` is still low exactly `timeout_lim` cycles later and high one cycle after that. Restart in the middle of the read phase is reached by withholding responses until reads are in flight.

// File: rtl/rdbk_traffic_gen.sv
module rdbk_traffic_gen #(
  parameter int PORT_ID = 0,
  parameter int NUM_REQ = 4,
  parameter int AW      = 16,
  parameter int BASE    = 'h100,
  parameter int TW      = 16,
  localparam int IW     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int TGW    = IW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [TW-1:0]  timeout_lim,
  output logic           req_valid,
  input  logic           req_ready,
  output logic           req_write,
  output logic [AW-1:0]  req_addr,
  output logic [TGW-1:0] req_tag,
  output logic [31:0]    req_wdata,
  input  logic           rsp_valid,
  input  logic [TGW-1:0] rsp_tag,
  input  logic [31:0]    rsp_data,
  output logic           gen_done,
  output logic           chk_pass,
  output logic           chk_fail
);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_WAIT, S_DONE} st_t;

  st_t              st;
  logic [IW-1:0]    idx;
  logic [NUM_REQ-1:0] pend;
  logic             err;
  logic [TW-1:0]    tcnt;

  function automatic logic [31:0] pattern(input logic [AW-1:0] a);
    return {8'(PORT_ID), ~a[7:0], 16'(a)};
  endfunction

  wire last = (idx == IW'(NUM_REQ - 1));
  wire fire = req_valid && req_ready;

  assign req_valid = (st == S_WR) || (st == S_RD);
  assign req_write = (st == S_WR);
  assign req_addr  = AW'(BASE) + AW'(idx);
  assign req_tag   = TGW'(idx);
  assign req_wdata = pattern(req_addr);

  wire [IW-1:0] rsp_idx = rsp_tag[IW-1:0];
  wire rsp_known = (rsp_tag < TGW'(NUM_REQ)) && pend[rsp_idx];
  wire rsp_bad   = rsp_valid &&
                   (!rsp_known || rsp_data != pattern(AW'(BASE) + AW'(rsp_idx)));

  wire [NUM_REQ-1:0] pend_clr = (rsp_valid && rsp_known) ? NUM_REQ'(1) << rsp_idx : '0;
  wire [NUM_REQ-1:0] pend_set = (st == S_RD && fire) ? NUM_REQ'(1) << idx : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  idx <= '0;  pend <= '0;  err <= 1'b0;  tcnt <= '0;
      gen_done <= 1'b0;  chk_pass <= 1'b0;  chk_fail <= 1'b0;
    end else if (start) begin
      st <= S_WR;  idx <= '0;  pend <= '0;  err <= 1'b0;  tcnt <= '0;
      gen_done <= 1'b0;  chk_pass <= 1'b0;  chk_fail <= 1'b0;
    end else begin
      case (st)
        S_WR: begin
          if (rsp_valid) err <= 1'b1;
          if (fire) begin
            idx <= last ? '0 : idx + 1'b1;
            if (last) begin
              st   <= S_RD;
              tcnt <= '0;
            end
          end
        end
        S_RD, S_WAIT: begin
          pend <= (pend & ~pend_clr) | pend_set;
          tcnt <= tcnt + 1'b1;
          if (rsp_bad) err <= 1'b1;
          if (st == S_WAIT && pend == '0) begin
            st       <= S_DONE;
            chk_pass <= !(err || rsp_bad);
            chk_fail <= err || rsp_bad;
          end else if (tcnt == timeout_lim) begin
            st       <= S_DONE;
            chk_fail <= 1'b1;
          end else if (st == S_RD && fire) begin
            idx <= last ? '0 : idx + 1'b1;
            if (last) begin
              st       <= S_WAIT;
              gen_done <= 1'b1;
            end
          end
        end
        S_DONE: begin
          if (rsp_valid) begin
            chk_fail <= 1'b1;
            chk_pass <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rdbk_traffic_chk.sv
module rdbk_traffic_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic          gen_done,
  input logic          chk_pass,
  input logic          chk_fail
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> !req_valid && !gen_done && !chk_pass && !chk_fail);

  a_r3_no_write_after_read: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_write && !start |=> !(req_valid && req_write));

  a_r4_write_held: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_write && !req_ready && !start |=> req_valid && req_write && $stable(req_addr));

  a_r5_pass_needs_gendone: assert property (@(posedge clk) disable iff (rst)
    chk_pass |-> gen_done);

  a_r5_gendone_sticky: assert property (@(posedge clk) disable iff (rst)
    gen_done && !start |=> gen_done);

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    chk_fail && !start |=> chk_fail);

  a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> !gen_done && !chk_pass && !chk_fail);

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(chk_pass && chk_fail));

endmodule

bind rdbk_traffic_gen rdbk_traffic_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .gen_done(gen_done),
  .chk_pass(chk_pass), .chk_fail(chk_fail)
);

// File: tb/tb_rdbk_traffic_gen.sv
module tb_rdbk_traffic_gen;
  localparam int N = 4, PID = 2, BASE = 'h100;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, start, req_ready, rsp_valid;
  logic [15:0] tlim;
  logic req_valid, req_write, gen_done, chk_pass, chk_fail;
  logic [15:0] req_addr;
  logic [2:0]  req_tag, rsp_tag;
  logic [31:0] req_wdata, rsp_data;

  rdbk_traffic_gen #(.PORT_ID(PID), .NUM_REQ(N), .AW(16), .BASE(BASE), .TW(16)) dut (
    .clk(clk), .rst(rst), .start(start), .timeout_lim(tlim),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_tag(req_tag), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .gen_done(gen_done), .chk_pass(chk_pass), .chk_fail(chk_fail));

  typedef struct { bit wr; logic [15:0] addr; logic [2:0] tag; } rq_t;
  typedef struct { logic [2:0] tag; logic [15:0] addr; } rd_t;
  typedef struct { logic [2:0] tag; logic [31:0] data; } mr_t;

  rq_t exp_q[$];
  rd_t rd_col[$];
  mr_t man_q[$];
  logic [31:0] mem [logic [15:0]];

  int tests = 0, fails = 0, cyc = 0;
  int rdy_mode = 1;
  bit auto_en = 1, rev_mode = 0, flush = 0;
  logic [2:0] bad_tag = 3'd7, drop_tag = 3'd7;

  function automatic logic [31:0] exp_data(input logic [15:0] a);
    return {8'(PID), ~a[7:0], a};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic arm();
    exp_q.delete();
    for (int i = 0; i < N; i++) exp_q.push_back('{1'b1, 16'(BASE + i), 3'(i)});
    for (int i = 0; i < N; i++) exp_q.push_back('{1'b0, 16'(BASE + i), 3'(i)});
  endtask

  // request ready pattern
  always @(posedge clk) begin
    #2;
    cyc++;
    case (rdy_mode)
      0: req_ready = 1'b0;
      1: req_ready = 1'b1;
      default: req_ready = (cyc % 3) != 1;
    endcase
  end

  // behavioural memory responder
  mr_t m;
  rd_t r;
  always @(posedge clk) begin
    #2;
    rsp_valid = 1'b0;
    if (man_q.size() != 0) begin
      m = man_q.pop_front();
      rsp_valid = 1'b1; rsp_tag = m.tag; rsp_data = m.data;
    end else if (auto_en && rd_col.size() != 0) begin
      if (rev_mode && !flush && rd_col.size() == N) flush = 1;
      if (!rev_mode || flush) begin
        r = rev_mode ? rd_col.pop_back() : rd_col.pop_front();
        if (rd_col.size() == 0) flush = 0;
        if (r.tag != drop_tag) begin
          rsp_valid = 1'b1; rsp_tag = r.tag;
          rsp_data = mem[r.addr] ^ ((r.tag == bad_tag) ? 32'h1 : 32'h0);
        end
      end
    end
  end

  // reference scoreboard, compared every clock
  bit p_stall = 0, p_start = 0, p_wr = 0;
  logic [15:0] p_addr = '0;
  rq_t e;
  always @(negedge clk) begin
    if (!rst) begin
      if (p_stall && !p_start)
        chk(req_valid && req_write == p_wr && req_addr == p_addr, "R4", "stalled request changed",
            32'(req_addr), 32'(p_addr));
      if (chk_pass || chk_fail)
        chk(!(chk_pass && chk_fail), "R11", "pass and fail together", {chk_pass, chk_fail}, 32'h1);
      if (req_valid && req_ready && !start) begin
        if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected request", 32'(req_addr), 32'hffff);
        else begin
          e = exp_q.pop_front();
          chk(req_write == e.wr, "R3", "command order", 32'(req_write), 32'(e.wr));
          chk(req_addr == e.addr, "R2", "address", 32'(req_addr), 32'(e.addr));
          chk(req_tag == e.tag, "R2", "tag", 32'(req_tag), 32'(e.tag));
          if (e.wr) begin
            chk(req_wdata == exp_data(e.addr), "R2", "write data", req_wdata, exp_data(e.addr));
            mem[req_addr] = req_wdata;
          end else rd_col.push_back('{req_tag, req_addr});
        end
      end
    end
    p_stall = !rst && req_valid && !req_ready;
    p_start = start; p_wr = req_write; p_addr = req_addr;
  end

  task automatic go();
    @(posedge clk) #3;
    arm(); rd_col.delete(); flush = 0;
    start = 1'b1;
    @(posedge clk) #3 start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (chk_pass || chk_fail) break;
    end
  endtask

  task automatic expect_flags(input string rq, input bit p, input bit f);
    chk(chk_pass == p, rq, "chk_pass", 32'(chk_pass), 32'(p));
    chk(chk_fail == f, rq, "chk_fail", 32'(chk_fail), 32'(f));
    chk(gen_done == 1'b1, rq, "gen_done", 32'(gen_done), 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1; start = 0; tlim = 16'd1000; req_ready = 1; rsp_valid = 0; rsp_tag = '0; rsp_data = '0;
    repeat (3) @(posedge clk);
    @(posedge clk) #3 rst = 0;
    @(negedge clk);
    chk(!req_valid && !gen_done && !chk_pass && !chk_fail, "R1", "reset state",
        {req_valid, gen_done, chk_pass, chk_fail}, 32'h0);
    repeat (5) @(negedge clk);
    chk(!req_valid, "R1", "idle without start", 32'(req_valid), 32'h0);

    // R2 R3 R6: in-order responses, no backpressure
    go(); wait_end();
    expect_flags("R6", 1'b1, 1'b0);
    chk(exp_q.size() == 0, "R3", "all requests issued", exp_q.size(), 32'h0);

    // R4 R5 R6: backpressure, responses held then returned in reverse
    rdy_mode = 2; rev_mode = 1;
    go();
    while (!gen_done) @(negedge clk);
    chk(!chk_pass && !chk_fail, "R5", "gen_done before responses", {chk_pass, chk_fail}, 32'h0);
    wait_end();
    expect_flags("R6", 1'b1, 1'b0);
    rdy_mode = 1; rev_mode = 0;

    // R7: corrupted payload
    bad_tag = 3'd2;
    go(); wait_end();
    expect_flags("R7", 1'b0, 1'b1);
    bad_tag = 3'd7;

    // R8: unknown tag during write phase
    go();
    man_q.push_back('{3'd6, 32'h0});
    wait_end();
    expect_flags("R8", 1'b0, 1'b1);

    // R8: extra response after a passing run
    go(); wait_end();
    expect_flags("R6", 1'b1, 1'b0);
    man_q.push_back('{3'd0, exp_data(16'(BASE))});
    repeat (3) @(negedge clk);
    chk(chk_fail && !chk_pass, "R8", "extra response after pass", {chk_pass, chk_fail}, 32'h1);

    // R9: one response dropped, timeout boundary
    tlim = 16'd40; drop_tag = 3'd1;
    go();
    do @(negedge clk); while (!(req_valid && !req_write));
    repeat (40) @(negedge clk);
    chk(!chk_fail && gen_done, "R9", "fail before limit", {gen_done, chk_fail}, 32'h2);
    @(negedge clk);
    chk(chk_fail && !chk_pass, "R9", "fail after limit", {chk_pass, chk_fail}, 32'h1);
    tlim = 16'd1000; drop_tag = 3'd7;

    // R10: restart during read phase
    auto_en = 0;
    go();
    while (rd_col.size() == 0) @(negedge clk);
    go();
    auto_en = 1;
    chk(!gen_done && !chk_pass && !chk_fail, "R10", "flags cleared by start",
        {gen_done, chk_pass, chk_fail}, 32'h0);
    chk(req_valid && req_write && req_addr == 16'(BASE), "R10", "restart at first write",
        32'(req_addr), 32'(BASE));
    wait_end();
    expect_flags("R10", 1'b1, 1'b0);

    // R1: synchronous reset mid-run
    rdy_mode = 0;
    go();
    repeat (2) @(negedge clk);
    @(posedge clk) #3 rst = 1; exp_q.delete(); rd_col.delete();
    @(posedge clk) #3 rst = 0;
    @(negedge clk);
    chk(!req_valid && !gen_done && !chk_pass && !chk_fail, "R1", "state after mid-run reset",
        {req_valid, gen_done, chk_pass, chk_fail}, 32'h0);
    rdy_mode = 1;
    repeat (4) @(negedge clk);
    chk(!req_valid, "R1", "idle after reset", 32'(req_valid), 32'h0);
    go(); wait_end();
    expect_flags("R6", 1'b1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule